// File: doc/BRIEF.md
# Shift Queue with Entry Invalidation

This block is a small first-in first-out buffer made of a chain of registers. It holds per-lane memory requests while a coalescing stage decides which of them can be merged into a wider access. New requests arrive on a ready/valid enqueue port. The oldest live request is offered on a ready/valid dequeue port taken from slot 0, the head. Entries move one slot toward the head each time the head is removed.

A cancel mask with one bit per slot lets the coalescing logic withdraw requests that were absorbed into a merged access. Bit i of the mask addresses the entry that currently sits i slots behind the head, with bit 0 meaning the head. A cancelled entry loses its live flag but keeps its slot, so a hole can sit in the middle of the chain. Holes that reach the head are shifted out on their own, one per cycle, without any handshake on the dequeue side. The consumer only ever sees live requests.

A three-state occupancy controller gates the shifting and the enqueue acceptance. Its states are `SQ_EMPTY` (no slot occupied), `SQ_PART` (some slots occupied) and `SQ_FULL` (every slot occupied). Its transitions are: `fill_first` (EMPTY to PART, or EMPTY to FULL when the depth is 1), `drain_last` (PART or FULL to EMPTY), `fill_up` (PART to FULL), `make_room` (FULL to PART), and hold in the same state. Each transition follows the occupancy the slots will have after the current cycle.

Top module: `sq_shift_queue`

## Requirements
- R1: After reset, every slot is unoccupied and not live, `deq_valid` is 0 and `enq_ready` is 1.
- R2: An enqueue into an empty queue is stored even when `deq_ready` is high in the same cycle. It is offered at the head on the next cycle.
- R3: Live requests leave in arrival order. A transfer happens in a cycle where `deq_valid` and `deq_ready` are both 1, and `deq_data` shows the oldest live request.
- R4: When bit i of `inv_mask` is set, the entry i slots behind the head (bit 0 = head) is cancelled and is never offered on the dequeue port. A bit that addresses an unoccupied slot has no effect.
- R5: A cancelled entry at the head is removed in that cycle without a handshake. `deq_valid` is 0 while a hole sits at the head.
- R6: A head that is cancelled in a cycle is gone on the next cycle, whatever the value of `deq_ready`. In the cycle of the cancel, `deq_valid` still reflects the registered head and not `inv_mask`.
- R7: When an enqueue and a removal of the head happen in the same cycle, the new request lands directly behind the last occupied entry that remains after the shift.
- R8: A cancelled entry still occupies its slot until it reaches the head and drains. A new request that arrives behind a cancelled tail is placed after it and stays live.
- R9: `enq_ready` is 0 only when all DEPTH slots are occupied and the head is not removed in that cycle.
- R10: The chain never shifts while the queue is empty, whatever `deq_ready` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A new request is offered |
| enq_ready | output | 1 | The queue accepts the offered request this cycle |
| enq_data | input | WIDTH | Payload of the new request |
| deq_valid | output | 1 | The head holds a live request |
| deq_ready | input | 1 | The consumer takes the head |
| deq_data | output | WIDTH | Payload of the head |
| inv_mask | input | DEPTH | Cancel mask, bit i is the slot i places behind the head |

## Verification
On every cycle, the assertions check the occupancy invariants. These are that occupied slots stay contiguous from the head, that a live slot is always occupied, that the controller state agrees with the head slot, that the chain never shifts while empty, that enqueue is refused only when full without a shift, and that a head cancel forces a shift. Arrival order, the exact slot a new request lands in after a shift, and the skipping of cancelled entries can only be shown by the bench. It runs a behavioural queue model alongside the design, through directed cases for empty, full, cancelled-head and cancelled-tail conditions and then a long randomized run.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        SQ_EMPTY = 2'd0,
        SQ_PART  = 2'd1,
        SQ_FULL  = 2'd2
    } sq_state_e;
endpackage

// File: rtl/sq_slot.sv
module sq_slot #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inv_self,
    input  logic             inv_next,
    input  logic [WIDTH-1:0] nxt_data,
    input  logic             nxt_valid,
    input  logic             nxt_used,
    output logic [WIDTH-1:0] data,
    output logic             valid,
    output logic             used
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
            used  <= 1'b0;
        end else if (wr_en) begin
            data  <= wr_data;
            valid <= 1'b1;
            used  <= 1'b1;
        end else if (shift) begin
            data  <= nxt_data;
            valid <= nxt_valid & ~inv_next;
            used  <= nxt_used;
        end else begin
            valid <= valid & ~inv_self;
        end
    end

    // R8
    live_is_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> used);
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] used,
    input  logic             head_valid,
    input  logic             deq_ready,
    input  logic             inv_head,
    input  logic             enq_valid,
    output logic             shift,
    output logic             enq_ready,
    output logic [DEPTH-1:0] wr_en,
    output sq_state_e        state
);
    sq_state_e        state_nx;
    logic             enq_fire;
    logic [DEPTH-1:0] kept_used;
    logic [DEPTH-1:0] post_used;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        shift     = (state != SQ_EMPTY) && (!head_valid || deq_ready || inv_head);
        enq_ready = (state != SQ_FULL) || shift;
        enq_fire  = enq_valid && enq_ready;
        kept_used = shift ? (used >> 1) : used;
        wr_en[0]  = enq_fire && !kept_used[0];
        for (int i = 1; i < DEPTH; i++) begin
            wr_en[i] = enq_fire && !kept_used[i] && kept_used[i-1];
        end
        post_used = kept_used | wr_en;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_EMPTY: begin
                if (enq_fire) state_nx = (DEPTH == 1) ? SQ_FULL : SQ_PART;
            end
            SQ_PART, SQ_FULL: begin
                if (!post_used[0])            state_nx = SQ_EMPTY;
                else if (post_used[DEPTH-1])  state_nx = SQ_FULL;
                else                          state_nx = SQ_PART;
            end
            default: state_nx = SQ_EMPTY;
        endcase
    end

    // R10
    empty_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_EMPTY) |-> !shift);
    // R9
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used[DEPTH-1] && !shift) |-> !enq_ready);
    // R6
    head_cancel_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used[0] && inv_head) |-> shift);
    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
    // R1
    state_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_EMPTY) == !used[0]);
endmodule

// File: rtl/sq_shift_queue.sv
module sq_shift_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    output logic             enq_ready,
    input  logic [WIDTH-1:0] enq_data,
    output logic             deq_valid,
    input  logic             deq_ready,
    output logic [WIDTH-1:0] deq_data,
    input  logic [DEPTH-1:0] inv_mask
);
    localparam int CHAIN = DEPTH + 1;

    logic [CHAIN-1:0][WIDTH-1:0] s_data;
    logic [CHAIN-1:0]            s_valid;
    logic [CHAIN-1:0]            s_used;
    logic [CHAIN-1:0]            inv_ext;
    logic [DEPTH-1:0]            wr_en;
    logic                        shift;
    sq_state_e                   state;

    assign s_data[DEPTH]  = '0;
    assign s_valid[DEPTH] = 1'b0;
    assign s_used[DEPTH]  = 1'b0;
    assign inv_ext        = {1'b0, inv_mask};

    sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .used       (s_used[DEPTH-1:0]),
        .head_valid (s_valid[0]),
        .deq_ready  (deq_ready),
        .inv_head   (inv_mask[0]),
        .enq_valid  (enq_valid),
        .shift      (shift),
        .enq_ready  (enq_ready),
        .wr_en      (wr_en),
        .state      (state)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sq_slot #(.WIDTH(WIDTH)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift     (shift),
            .wr_en     (wr_en[g]),
            .wr_data   (enq_data),
            .inv_self  (inv_ext[g]),
            .inv_next  (inv_ext[g+1]),
            .nxt_data  (s_data[g+1]),
            .nxt_valid (s_valid[g+1]),
            .nxt_used  (s_used[g+1]),
            .data      (s_data[g]),
            .valid     (s_valid[g]),
            .used      (s_used[g])
        );
    end

    assign deq_valid = s_valid[0];
    assign deq_data  = s_data[0];

    // R8
    contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_used[DEPTH-1:0] & ~(s_used[DEPTH-1:0] >> 1) & ~s_used[DEPTH-1:0]) == '0
        && ((s_used[DEPTH-1:1] & ~s_used[DEPTH-2:0]) == '0));
    // R2
    empty_enq_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_EMPTY && enq_valid) |=> (deq_valid && s_used[0]));
endmodule

// File: tb/sq_shift_queue_test.sv
module sq_shift_queue_test;
    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    typedef struct {
        logic [WIDTH-1:0] d;
        bit               v;
    } ent_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq_valid = 1'b0;
    logic             enq_ready;
    logic [WIDTH-1:0] enq_data = '0;
    logic             deq_valid;
    logic             deq_ready = 1'b0;
    logic [WIDTH-1:0] deq_data;
    logic [DEPTH-1:0] inv_mask = '0;

    int   n_vec = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    ent_t mq[$];

    always #2.5 clk = ~clk;

    sq_shift_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_ready (enq_ready),
        .enq_data  (enq_data),
        .deq_valid (deq_valid),
        .deq_ready (deq_ready),
        .deq_data  (deq_data),
        .inv_mask  (inv_mask)
    );

    task automatic step(input bit ev, input logic [WIDTH-1:0] ed, input bit dr,
                        input logic [DEPTH-1:0] inv, input string tag);
        bit exp_dv, exp_er, shf, bad;
        logic [WIDTH-1:0] exp_dd;
        @(negedge clk);
        enq_valid = ev; enq_data = ed; deq_ready = dr; inv_mask = inv;
        #1;
        exp_dv = (mq.size() > 0) && mq[0].v;
        exp_dd = exp_dv ? mq[0].d : '0;
        shf    = (mq.size() > 0) && (!mq[0].v || dr || inv[0]);
        exp_er = (mq.size() < DEPTH) || shf;
        bad = (deq_valid !== exp_dv) || (enq_ready !== exp_er)
              || (exp_dv && deq_data !== exp_dd);
        n_vec++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: deq_valid=%0b deq_data=%h enq_ready=%0b exp %0b %h %0b",
                     tag, deq_valid, deq_data, enq_ready, exp_dv, exp_dd, exp_er);
        end
        for (int i = 0; i < mq.size(); i++) if (inv[i]) mq[i].v = 0;
        if (shf) void'(mq.pop_front());
        if (ev && exp_er) mq.push_back('{d: ed, v: 1'b1});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle state straight after reset
        step(0, 8'h00, 0, 4'b0000, "R1");
        // R10: consumer ready while empty, nothing shifts
        step(0, 8'h00, 1, 4'b1111, "R10");
        // R2: enqueue into empty with deq_ready high
        step(1, 8'hA5, 1, 4'b0000, "R2");
        step(0, 8'h00, 0, 4'b0000, "R2");
        // R3: order of live entries
        step(1, 8'h11, 0, 4'b0000, "R3");
        step(1, 8'h22, 0, 4'b0000, "R3");
        step(1, 8'h33, 0, 4'b0000, "R9");
        // R9: full, head live, consumer stalled
        step(1, 8'h44, 0, 4'b0000, "R9");
        // R6: cancel live head with deq_ready low
        step(0, 8'h00, 0, 4'b0001, "R6");
        // R7: enqueue and dequeue together
        step(1, 8'h55, 1, 4'b0000, "R7");
        step(1, 8'h66, 1, 4'b0000, "R7");
        // R4: cancel middle entries
        step(0, 8'h00, 0, 4'b0110, "R4");
        step(0, 8'h00, 1, 4'b0000, "R3");
        // R5: holes at head drain with no handshake
        step(0, 8'h00, 0, 4'b0000, "R5");
        step(0, 8'h00, 0, 4'b0000, "R5");
        step(0, 8'h00, 1, 4'b0000, "R3");
        repeat (4) step(0, 8'h00, 1, 4'b0000, "R3");
        // R8: enqueue behind a cancelled tail
        step(1, 8'h71, 0, 4'b0000, "R8");
        step(1, 8'h72, 0, 4'b0000, "R8");
        step(1, 8'h73, 0, 4'b0100, "R8");
        step(1, 8'h74, 0, 4'b0000, "R8");
        step(0, 8'h00, 1, 4'b0000, "R8");
        repeat (5) step(0, 8'h00, 1, 4'b0000, "R8");
        // R4: cancel bits on unoccupied slots
        step(1, 8'h81, 0, 4'b1110, "R4");
        step(0, 8'h00, 1, 4'b0000, "R4");
        // randomized mix
        for (int k = 0; k < 4000; k++) begin
            logic [DEPTH-1:0] iv;
            iv = ($urandom_range(0, 5) == 0) ? DEPTH'(1 << $urandom_range(0, DEPTH-1)) : '0;
            if ($urandom_range(0, 15) == 0) iv = DEPTH'($urandom);
            step(bit'($urandom_range(0, 2) != 0), WIDTH'($urandom), bit'($urandom_range(0, 2) == 0),
                 iv, "R3");
        end
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule